// File: doc/BRIEF.md
# Redirection Table Register Front End

This block is the software-facing register file of an I/O interrupt redirection controller. A bus master reaches it through two byte offsets: an 8-bit select register and a 32-bit data window. The select value chooses what the window exposes: the controller identifier, a read-only version word, an arbitration word, or one 32-bit half of a 64-bit redirection entry. There is one entry per interrupt input pin.

Each entry holds a vector, delivery mode, destination mode, polarity, trigger mode, mask and destination. Two status bits are owned by the delivery logic rather than by software. The delivery-status bit follows the `dlv_pend` input. The remote-IRR bit is set and cleared by `remirr_set` and `remirr_clr`. Window writes leave both status bits alone. There is one exception: when a write leaves an entry edge-triggered, its remote-IRR bit is cleared. After each window write to an entry, the block gives the delivery logic two registered one-cycle pulses per pin. One reports a change of the mask bit. The other reports that a level-triggered entry was rewritten.

Top module: `irq_redir_regs`

## Requirements
- R1: Offset 0x00 is the select register. A write there keeps only data bits 7:0, and a read there returns them zero-extended. A read at any offset other than 0x00 or 0x10 returns zero. A write at such an offset changes no state.
- R2: Select 0x01 is the version word: pin count minus one in bits 23:16 (0x17 for 24 pins), the version code (default 0x11) in bits 7:0, and zeros elsewhere. Writes to it are ignored.
- R3: The 4-bit identifier is written through select 0x00 from data bits 27:24. Selects 0x00 and 0x02 both read it back in bits 27:24, with all other bits zero. A write through select 0x02 leaves the identifier unchanged.
- R4: Select 0x10+2n reaches bits 31:0 of entry n, and select 0x11+2n reaches bits 63:32. A written half reads back unchanged, apart from bits 12 and 14.
- R5: A window read with select 0x03–0x0F, or with a select whose entry index is 24 or more (0x40–0xFF), returns 0xFFFFFFFF. A window write with such a select changes no entry.
- R6: A window write never alters bit 14 (remote IRR) or bit 12 (delivery status) of an entry. Bit 12 follows the pin's `dlv_pend` input, one cycle late.
- R7: If an entry's bit 15 (trigger mode, 1 = level) is 0 after a window write, that entry's bit 14 reads 0.
- R8: After reset, every entry reads 0x00010000 in its low half (mask bit 16 set) and 0 in its high half. The select register and the identifier are 0.
- R9: A window write that changes an entry's bit 16 raises `mask_chg_pulse[n]` for exactly the cycle after the write, and `mask_chg_val[n]` then equals the new mask. A write that leaves the mask unchanged gives no pulse.
- R10: A window write to either half of an entry that leaves bit 15 at 1 raises `level_rewr_pulse[n]` in the cycle after the write. An edge-triggered result raises no pulse.
- R11: `remirr_set[n]` sets bit 14 only while the entry is level-triggered. `remirr_clr[n]` clears bit 14.
- R12: Read data is registered. It appears in the cycle after a read and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Low byte of the access address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| remirr_set | input | NPINS | Per pin: set remote IRR (level entries only) |
| remirr_clr | input | NPINS | Per pin: clear remote IRR |
| dlv_pend | input | NPINS | Per pin: delivery-status value to show in bit 12 |
| mask_chg_pulse | output | NPINS | Per pin: mask bit changed by the last write |
| mask_chg_val | output | NPINS | Per pin: current mask bit |
| level_rewr_pulse | output | NPINS | Per pin: level-triggered entry rewritten |

## Verification
The per-cycle assertions cover the bus-level rules. Offsets other than the two decoded ones read as zero, the select readback has zero upper bits, and read data holds between reads. Each mask-change or level-rewrite pulse must follow a window write, and at most one pin pulses at a time. Other behaviour is only shown by the bench scenarios: the index decode, the all-ones result for unreachable selects, preservation of the status bits, the edge-trigger clearing rule, and identifier write protection. The bench sweeps all 256 select values after reset and again after a pattern has been written to every entry. It also runs the remote-IRR sequence on a single pin.

// File: rtl/irq_redir_pkg.sv
// Shared constants and types for the redirection register front end.
// Assumes 8-bit select values and 64-bit entries split into two halves.
package irq_redir_pkg;
    localparam int F_DLV  = 12;   // delivery status, hardware owned
    localparam int F_RIRR = 14;   // remote IRR, hardware owned
    localparam int F_TRIG = 15;   // 1 = level, 0 = edge
    localparam int F_MASK = 16;   // 1 = masked

    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;

    localparam logic [7:0] SEL_ID   = 8'h00;
    localparam logic [7:0] SEL_VER  = 8'h01;
    localparam logic [7:0] SEL_ARB  = 8'h02;
    localparam logic [7:0] SEL_TBL  = 8'h10;

    localparam int IDX_W = 7;

    localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        TGT_ID, TGT_VER, TGT_ARB, TGT_ENT, TGT_VOID
    } win_tgt_e;

    typedef struct packed {
        win_tgt_e         tgt;
        logic [IDX_W-1:0] idx;
        logic             hi;
    } win_dec_t;
endpackage

// File: rtl/irq_redir_decode.sv
// Decodes the select register into a window target.
// Assumes selects below the table base other than 0..2 hit nothing.
module irq_redir_decode
    import irq_redir_pkg::*;
#(
    parameter int NPINS = 24
) (
    input  logic [7:0] sel,
    output win_dec_t   dec
);
    localparam logic [IDX_W-1:0] NPINS_W = IDX_W'(NPINS);

    logic [7:0] offs;

    // Classify the select value and derive entry index and half.
    always_comb begin
        offs    = sel - SEL_TBL;
        dec.idx = offs[7:1];
        dec.hi  = sel[0];
        if (sel == SEL_ID)
            dec.tgt = TGT_ID;
        else if (sel == SEL_VER)
            dec.tgt = TGT_VER;
        else if (sel == SEL_ARB)
            dec.tgt = TGT_ARB;
        else if (sel >= SEL_TBL && offs[7:1] < NPINS_W)
            dec.tgt = TGT_ENT;
        else
            dec.tgt = TGT_VOID;
    end
endmodule

// File: rtl/irq_redir_entry.sv
// One 64-bit redirection entry with protected status bits.
// Assumes at most one half is written per cycle.
module irq_redir_entry
    import irq_redir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        remirr_set,
    input  logic        remirr_clr,
    input  logic        dlv_pend,
    output logic [63:0] ent,
    output logic        mask_chg,
    output logic        level_rewr
);
    logic [63:0] ent_q;
    logic [63:0] nxt;
    logic        wr_any;

    assign wr_any = wr_lo | wr_hi;

    // Merge written half, restore owned bits, apply status updates.
    always_comb begin
        nxt = ent_q;
        if (wr_lo) nxt[31:0]  = wdata;
        if (wr_hi) nxt[63:32] = wdata;
        nxt[F_RIRR] = ent_q[F_RIRR];
        nxt[F_DLV]  = dlv_pend;
        if (remirr_set && nxt[F_TRIG]) nxt[F_RIRR] = 1'b1;
        if (remirr_clr)                nxt[F_RIRR] = 1'b0;
        if (wr_any && !nxt[F_TRIG])    nxt[F_RIRR] = 1'b0;
    end

    // Entry storage and one-cycle notification pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q      <= ENT_RESET;
            mask_chg   <= 1'b0;
            level_rewr <= 1'b0;
        end else begin
            ent_q      <= nxt;
            mask_chg   <= wr_any && (nxt[F_MASK] != ent_q[F_MASK]);
            level_rewr <= wr_any && nxt[F_TRIG];
        end
    end

    assign ent = ent_q;
endmodule

// File: rtl/irq_redir_rdmux.sv
// Window read multiplexer: builds the 32-bit word the select points to.
// Assumes the decode already marks unreachable selects as void.
module irq_redir_rdmux
    import irq_redir_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  win_dec_t                dec,
    input  logic [3:0]              id,
    input  logic [NPINS-1:0][63:0]  ents,
    output logic [31:0]             rword
);
    localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

    logic [63:0] pick;

    // Select the addressed entry; an out-of-range index is never used.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NPINS; i++)
            if (dec.idx == IDX_W'(i)) pick = ents[i];
    end

    // Form the read word for the current target.
    always_comb begin
        unique case (dec.tgt)
            TGT_ID, TGT_ARB: rword = {4'h0, id, 24'h0};
            TGT_VER:         rword = {8'h00, MAXPIN, 8'h00, VERSION};
            TGT_ENT:         rword = dec.hi ? pick[63:32] : pick[31:0];
            default:         rword = '1;
        endcase
    end
endmodule

// File: rtl/irq_redir_regs.sv
// Top: select/window register front end of the redirection controller.
// Assumes 16-byte aligned accesses; only the low address byte is given.
module irq_redir_regs
    import irq_redir_pkg::*;
#(
    parameter int         NPINS   = 24,
    parameter logic [7:0] VERSION = 8'h11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] remirr_set,
    input  logic [NPINS-1:0] remirr_clr,
    input  logic [NPINS-1:0] dlv_pend,
    output logic [NPINS-1:0] mask_chg_pulse,
    output logic [NPINS-1:0] mask_chg_val,
    output logic [NPINS-1:0] level_rewr_pulse
);
    logic [7:0]             sel_q;
    logic [3:0]             id_q;
    logic [31:0]            rdata_q;
    win_dec_t               dec;
    logic [NPINS-1:0][63:0] ents;
    logic [31:0]            rword;
    logic                   sel_wr, win_wr, rd;

    assign sel_wr = bus_valid &  bus_write & (bus_addr == OFS_SEL);
    assign win_wr = bus_valid &  bus_write & (bus_addr == OFS_WIN);
    assign rd     = bus_valid & ~bus_write;

    irq_redir_decode #(.NPINS(NPINS)) dec_i (
        .sel (sel_q),
        .dec (dec)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic hit;
        assign hit = win_wr && (dec.tgt == TGT_ENT) && (dec.idx == IDX_W'(g));
        irq_redir_entry ent_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_lo      (hit && !dec.hi),
            .wr_hi      (hit &&  dec.hi),
            .wdata      (bus_wdata),
            .remirr_set (remirr_set[g]),
            .remirr_clr (remirr_clr[g]),
            .dlv_pend   (dlv_pend[g]),
            .ent        (ents[g]),
            .mask_chg   (mask_chg_pulse[g]),
            .level_rewr (level_rewr_pulse[g])
        );
        assign mask_chg_val[g] = ents[g][F_MASK];
    end

    irq_redir_rdmux #(.NPINS(NPINS), .VERSION(VERSION)) mux_i (
        .dec   (dec),
        .id    (id_q),
        .ents  (ents),
        .rword (rword)
    );

    // Select register: low byte of a write at the select offset.
    always_ff @(posedge clk) begin
        if (!rst_n)      sel_q <= '0;
        else if (sel_wr) sel_q <= bus_wdata[7:0];
    end

    // Identifier: only writable through the ID select.
    always_ff @(posedge clk) begin
        if (!rst_n)                           id_q <= '0;
        else if (win_wr && dec.tgt == TGT_ID) id_q <= bus_wdata[27:24];
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd) begin
            if (bus_addr == OFS_SEL)      rdata_q <= {24'h0, sel_q};
            else if (bus_addr == OFS_WIN) rdata_q <= rword;
            else                          rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/irq_redir_chk.sv
// Bus and pulse properties of the register front end, bound to the top.
module irq_redir_chk #(
    parameter int NPINS = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] mask_chg_pulse,
    input logic [NPINS-1:0] level_rewr_pulse
);
    AST_OTHER_OFS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr != 8'h00 && bus_addr != 8'h10)
        |=> bus_rdata == 32'h0); // R1

    AST_SEL_READ_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr == 8'h00)
        |=> bus_rdata[31:8] == 24'h0); // R1

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata)); // R12

    AST_MASK_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_chg_pulse) |-> $past(bus_valid && bus_write && bus_addr == 8'h10)); // R9

    AST_MASK_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask_chg_pulse)); // R9

    AST_LEVEL_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|level_rewr_pulse) |-> $past(bus_valid && bus_write && bus_addr == 8'h10)); // R10

    AST_LEVEL_PULSE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(level_rewr_pulse)); // R10
endmodule

bind irq_redir_regs irq_redir_chk #(.NPINS(NPINS)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_valid        (bus_valid),
    .bus_write        (bus_write),
    .bus_addr         (bus_addr),
    .bus_rdata        (bus_rdata),
    .mask_chg_pulse   (mask_chg_pulse),
    .level_rewr_pulse (level_rewr_pulse)
);

// File: tb/irq_redir_regs_tb.sv
`timescale 1ns/1ps
module irq_redir_regs_tb_top;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] remirr_set = '0, remirr_clr = '0, dlv_pend = '0;
    logic [NP-1:0] mask_chg_pulse, mask_chg_val, level_rewr_pulse;

    int errs = 0;
    int chks = 0;

    logic [63:0]   m_ent [NP];
    logic [3:0]    m_id;
    logic [NP-1:0] cap_mask, cap_mval, cap_lvl;

    always #2.5 clk = ~clk;

    irq_redir_regs dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .remirr_set(remirr_set), .remirr_clr(remirr_clr), .dlv_pend(dlv_pend),
        .mask_chg_pulse(mask_chg_pulse), .mask_chg_val(mask_chg_val),
        .level_rewr_pulse(level_rewr_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        chks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        cap_mask = mask_chg_pulse; cap_mval = mask_chg_val; cap_lvl = level_rewr_pulse;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
        bus_wr(8'h00, {24'h0, s});
        bus_rd(8'h10, d);
    endtask

    task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
        bus_wr(8'h00, {24'h0, s});
        bus_wr(8'h10, d);
    endtask

    function automatic logic [31:0] exp_rd(input int s);
        int idx;
        if (s == 0 || s == 2) return {4'h0, m_id, 24'h0};
        if (s == 1) return 32'h0017_0011;
        idx = (s - 16) >>> 1;
        if (s >= 16 && idx < NP) return s[0] ? m_ent[idx][63:32] : m_ent[idx][31:0];
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] lo_w(input int n);
        logic [7:0] b;
        b = 8'(n);
        return {8'(n * 7 + 1), 7'h55, b[0], b[1], 3'b111, 4'h0, 8'(n + 48)};
    endfunction

    function automatic logic [31:0] hi_w(input int n);
        return {8'(n ^ 165), 24'(n * 3 + 1)};
    endfunction

    task automatic sweep(input string tag);
        logic [31:0] d;
        for (int s = 0; s < 256; s++) begin
            win_rd(8'(s), d);
            check(tag, d, exp_rd(s));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        m_id = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state; R2 R3 R4 R5 readback across all selects
        bus_rd(8'h00, d);
        check("R8 select reset", d, 32'h0);
        sweep("R8/R5 reset sweep");

        // R1 select keeps low byte; other offsets read zero, writes ignored
        bus_wr(8'h00, 32'h1234_56AB);
        bus_rd(8'h00, d);
        check("R1 select low byte", d, 32'h0000_00AB);
        bus_wr(8'h20, 32'hFFFF_FFFF);
        bus_wr(8'hF0, 32'h0000_0011);
        bus_rd(8'h00, d);
        check("R1 stray write ignored", d, 32'h0000_00AB);
        bus_rd(8'h20, d);
        check("R1 other offset zero", d, 32'h0);
        bus_rd(8'h11, d);
        check("R1 misaligned offset zero", d, 32'h0);
        // R12 read data holds while idle
        repeat (3) @(negedge clk);
        check("R12 rdata hold", bus_rdata, 32'h0);
        bus_rd(8'h00, d);
        repeat (2) @(negedge clk);
        check("R12 rdata hold after read", bus_rdata, 32'h0000_00AB);

        // R3 identifier write through select 0, protected at select 2
        win_wr(8'h00, 32'hFFFF_FFFF);
        m_id = 4'hF;
        win_rd(8'h00, d);
        check("R3 id readback", d, 32'h0F00_0000);
        win_wr(8'h02, 32'h0000_0000);
        win_rd(8'h02, d);
        check("R3 arb write ignored", d, 32'h0F00_0000);
        win_wr(8'h00, 32'h5A00_0000);
        m_id = 4'hA;
        win_rd(8'h02, d);
        check("R3 arb mirrors id", d, 32'h0A00_0000);
        // R2 version write ignored
        win_wr(8'h01, 32'h0000_0000);
        win_rd(8'h01, d);
        check("R2 version fixed", d, 32'h0017_0011);

        // R4 R9 R10 pattern every entry; check pulses per write
        for (int n = 0; n < NP; n++) begin
            v = lo_w(n);
            win_wr(8'(16 + 2 * n), v);
            m_ent[n][31:0] = v & ~32'h0000_5000;
            check("R9 mask pulse", 32'(cap_mask), v[16] ? 32'h0 : 32'(1) << n);
            if (!v[16]) check("R9 mask value", 32'(cap_mval[n]), 32'h0);
            check("R10 level pulse lo", 32'(cap_lvl), v[15] ? 32'(1) << n : 32'h0);
            win_wr(8'(17 + 2 * n), hi_w(n));
            m_ent[n][63:32] = hi_w(n);
            check("R9 no pulse on hi", 32'(cap_mask), 32'h0);
            check("R10 level pulse hi", 32'(cap_lvl), v[15] ? 32'(1) << n : 32'h0);
        end
        sweep("R4 pattern sweep");

        // R5 unreachable selects: writes leave every entry untouched
        win_wr(8'h40, 32'hFFFF_FFFF);
        win_wr(8'h05, 32'hFFFF_FFFF);
        win_wr(8'hFF, 32'h0000_0000);
        check("R5 no pulse", 32'(cap_mask | cap_lvl), 32'h0);
        sweep("R5 after void writes");

        // R11 remote IRR set on level pin 6 (bit15=1, mask 0)
        @(negedge clk); remirr_set[6] = 1'b1;
        @(negedge clk); remirr_set[6] = 1'b0;
        m_ent[6][14] = 1'b1;
        win_rd(8'h1C, d);
        check("R11 remote irr set", d, m_ent[6][31:0]);
        // R6 status bits survive a write of zeros to them
        @(negedge clk); dlv_pend[6] = 1'b1;
        m_ent[6][12] = 1'b1;
        win_wr(8'h1C, 32'h0000_8041);
        m_ent[6][31:0] = 32'h0000_8041 | 32'h0000_5000;
        check("R9 unchanged mask no pulse", 32'(cap_mask), 32'h0);
        win_rd(8'h1C, d);
        check("R6 status preserved", d, m_ent[6][31:0]);
        win_wr(8'h1C, 32'h0000_7042);
        m_ent[6][31:0] = 32'h0000_3042;
        win_rd(8'h1C, d);
        check("R7 edge clears remote irr", d, 32'h0000_3042);
        check("R10 no pulse on edge", 32'(cap_lvl), 32'h0);
        @(negedge clk); remirr_set[6] = 1'b1;
        @(negedge clk); remirr_set[6] = 1'b0;
        win_rd(8'h1C, d);
        check("R11 edge ignores set", d, 32'h0000_3042);
        win_wr(8'h1C, 32'h0001_8043);
        check("R9 mask set pulse", 32'(cap_mask), 32'(1) << 6);
        check("R9 mask set value", 32'(cap_mval[6]), 32'h1);
        @(negedge clk); remirr_set[6] = 1'b1;
        @(negedge clk); remirr_set[6] = 1'b0; remirr_clr[6] = 1'b1;
        @(negedge clk); remirr_clr[6] = 1'b0; dlv_pend[6] = 1'b0;
        @(negedge clk);
        win_rd(8'h1C, d);
        check("R11 clear remote irr", d, 32'h0001_8043);

        $display("  Result: errors=%0d of %0d checks", errs, chks);
        $finish;
    end
endmodule